// File: doc/BRIEF.md
# Bridge Command Frame Generator

This block turns one transaction request into the byte sequence that a host sends across a single-wire serial link to a remote bridge that runs an I2C transaction on its behalf. A request names a transaction kind, a 7-bit I2C target address, a write length, a read length and, for the speed-setting frame, an I2C rate in kHz. Once a request is accepted, the block sends the frame one byte at a time on a valid/ready output. It pulls write payload bytes from a separate valid/ready input and passes them straight through. It also keeps a running CRC16 over the bytes it sends and appends that check value at the end.

A request is taken only while the block is idle. A request with a bad length, rate or kind is refused with a one-cycle error pulse and sends nothing. A one-cycle done pulse marks the end of each frame. The single-wire bit timing, bus reset and device selection belong to the layer beneath this block.

Top module: `bridge_frame_gen`

## Requirements
- R1: The first byte of a frame is set by `req_kind`: 0 gives 0x4B (write, stop), 1 gives 0x5A (write, no stop), 2 gives 0x87 (read, stop), 3 gives 0x2D (write then read, stop) and 4 gives 0xD2 (speed setting). Kind codes 5 to 7 are refused in the same way as in R7.
- R2: The second byte of a read, write or write-then-read frame is `req_addr` in bits 7:1. Bit 0 is 1 for kind 2 and 0 for kinds 0, 1 and 3.
- R3: A write frame (kinds 0 and 1) is the command byte, the address byte, the write length, the write length count of payload bytes taken in order from the payload input, and then two check bytes.
- R4: A read frame (kind 2) is the command byte, the address byte, the read length and two check bytes. It carries no payload and takes nothing from the payload input.
- R5: A write-then-read frame (kind 3) is the command byte, the address byte, the write length, the payload, the read length and two check bytes. The check value includes the read length byte.
- R6: The check value is a CRC16 with polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001), starting from 0. It covers every frame byte before the check bytes. It is sent bit-inverted, low byte first.
- R7: A request whose write length (kinds 0, 1, 3) or read length (kinds 2, 3) is 0 or greater than 255 produces an `err` pulse in the cycle after the request. No byte is sent and the block stays idle.
- R8: Kind 4 sends 0xD2 followed by 0, 1 or 2 for a `req_rate_khz` of 100, 400 or 900. It has no check bytes. Any other rate is refused in the same way as in R7.
- R9: `done` is high for exactly one cycle, in the cycle after the last byte of a frame is accepted at the output.
- R10: `req_ready` is high only while no frame is in progress. A request presented while a frame is in progress has no effect on that frame.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. `pl_ready` is high only while payload is being passed through and `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_kind | input | 3 | Transaction kind code |
| req_addr | input | 7 | I2C target address |
| req_wlen | input | 9 | Write payload length |
| req_rlen | input | 9 | Read length |
| req_rate_khz | input | 10 | Requested I2C rate for kind 4 |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Frame byte present |
| out_ready | input | 1 | Frame byte taken downstream |
| out_data | output | 8 | Frame byte |
| done | output | 1 | Frame finished pulse |
| err | output | 1 | Request refused pulse |

## Verification
The output-hold property assumes that the payload source keeps `pl_data` steady while `pl_valid` is high and the byte has not been taken. The output takes its data straight from the payload during the payload phase, so a source that changes the byte early would break the property. The stimulus meets this assumption by keeping a random-asserted `pl_valid` high, with the same byte, until `pl_ready` takes that byte. The property on the first byte after a request assumes that requests change only at clock edges, and the stimulus drives every input half a period away from the active edge.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

    localparam logic [7:0] OP_WR_STOP   = 8'h4B;
    localparam logic [7:0] OP_WR_NOSTOP = 8'h5A;
    localparam logic [7:0] OP_RD_STOP   = 8'h87;
    localparam logic [7:0] OP_WRRD_STOP = 8'h2D;
    localparam logic [7:0] OP_SPEED     = 8'hD2;

    typedef enum logic [2:0] {
        KIND_WR_STOP   = 3'd0,
        KIND_WR_NOSTOP = 3'd1,
        KIND_RD        = 3'd2,
        KIND_WRRD      = 3'd3,
        KIND_SPEED     = 3'd4
    } kind_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WLEN,
        PH_PAY,
        PH_RLEN,
        PH_CRC_LO,
        PH_CRC_HI,
        PH_SPEED
    } phase_e;

    // One byte through a reflected CRC, least significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                             input logic [7:0]  byte_in,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = crc_in ^ {8'h00, byte_in};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/bfg_crc16.sv
module bfg_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'hA001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             update,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc
);
    import bfg_pkg::*;

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (update) begin
            crc_d = crc_step(crc_q, data, POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/bfg_req_check.sv
module bfg_req_check #(
    parameter int LEN_W   = 9,
    parameter int MAX_LEN = 255,
    parameter int RATE_W  = 10
) (
    input  logic [2:0]        kind,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [LEN_W-1:0]  rlen,
    input  logic [RATE_W-1:0] rate_khz,
    output logic              ok,
    output logic [1:0]        speed_code
);
    import bfg_pkg::*;

    logic wlen_ok, rlen_ok, rate_ok;

    always_comb begin
        wlen_ok = (wlen != '0) && (wlen <= LEN_W'(MAX_LEN));
        rlen_ok = (rlen != '0) && (rlen <= LEN_W'(MAX_LEN));

        rate_ok    = 1'b1;
        speed_code = 2'd0;
        case (rate_khz)
            RATE_W'(100): speed_code = 2'd0;
            RATE_W'(400): speed_code = 2'd1;
            RATE_W'(900): speed_code = 2'd2;
            default:      rate_ok    = 1'b0;
        endcase

        case (kind_e'(kind))
            KIND_WR_STOP,
            KIND_WR_NOSTOP: ok = wlen_ok;
            KIND_RD:        ok = rlen_ok;
            KIND_WRRD:      ok = wlen_ok && rlen_ok;
            KIND_SPEED:     ok = rate_ok;
            default:        ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/bridge_frame_gen.sv
module bridge_frame_gen #(
    parameter int          LEN_W   = 9,
    parameter int          MAX_LEN = 255,
    parameter int          RATE_W  = 10,
    parameter logic [15:0] POLY    = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [6:0]        req_addr,
    input  logic [LEN_W-1:0]  req_wlen,
    input  logic [LEN_W-1:0]  req_rlen,
    input  logic [RATE_W-1:0] req_rate_khz,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [7:0]        pl_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              done,
    output logic              err
);
    import bfg_pkg::*;

    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int CRC_W = 16;

    typedef struct packed {
        phase_e           phase;
        kind_e            kind;
        logic [6:0]       addr;
        logic [CNT_W-1:0] wlen;
        logic [CNT_W-1:0] rlen;
        logic [1:0]       speed;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             err;
    } frm_state_t;

    frm_state_t s_d, s_q;

    logic             req_ok;
    logic [1:0]       req_speed;
    logic             beat;
    logic             crc_clear;
    logic             crc_update;
    logic [CRC_W-1:0] crc;

    bfg_req_check #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN),
        .RATE_W  (RATE_W)
    ) u_check (
        .kind       (req_kind),
        .wlen       (req_wlen),
        .rlen       (req_rlen),
        .rate_khz   (req_rate_khz),
        .ok         (req_ok),
        .speed_code (req_speed)
    );

    // Output side of the handshake and byte selection.
    always_comb begin
        req_ready = (s_q.phase == PH_IDLE);
        out_valid = (s_q.phase != PH_IDLE) && ((s_q.phase != PH_PAY) || pl_valid);
        pl_ready  = (s_q.phase == PH_PAY) && out_ready;
        beat      = out_valid && out_ready;

        case (s_q.phase)
            PH_CMD: begin
                case (s_q.kind)
                    KIND_WR_STOP:   out_data = OP_WR_STOP;
                    KIND_WR_NOSTOP: out_data = OP_WR_NOSTOP;
                    KIND_RD:        out_data = OP_RD_STOP;
                    KIND_WRRD:      out_data = OP_WRRD_STOP;
                    default:        out_data = OP_SPEED;
                endcase
            end
            PH_ADDR:   out_data = {s_q.addr, (s_q.kind == KIND_RD)};
            PH_WLEN:   out_data = 8'(s_q.wlen);
            PH_PAY:    out_data = pl_data;
            PH_RLEN:   out_data = 8'(s_q.rlen);
            PH_CRC_LO: out_data = ~crc[7:0];
            PH_CRC_HI: out_data = ~crc[15:8];
            PH_SPEED:  out_data = {6'd0, s_q.speed};
            default:   out_data = 8'h00;
        endcase

        crc_clear  = (s_q.phase == PH_IDLE) && req_valid && req_ok;
        crc_update = beat && (s_q.phase inside {PH_CMD, PH_ADDR, PH_WLEN, PH_PAY, PH_RLEN});
    end

    bfg_crc16 #(
        .CRC_W (CRC_W),
        .POLY  (POLY)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .update (crc_update),
        .data   (out_data),
        .crc    (crc)
    );

    // Next-state computation.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;

        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        s_d.phase = PH_CMD;
                        s_d.kind  = kind_e'(req_kind);
                        s_d.addr  = req_addr;
                        s_d.wlen  = CNT_W'(req_wlen);
                        s_d.rlen  = CNT_W'(req_rlen);
                        s_d.speed = req_speed;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_CMD: begin
                if (beat) s_d.phase = (s_q.kind == KIND_SPEED) ? PH_SPEED : PH_ADDR;
            end
            PH_SPEED: begin
                if (beat) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            PH_ADDR: begin
                if (beat) s_d.phase = (s_q.kind == KIND_RD) ? PH_RLEN : PH_WLEN;
            end
            PH_WLEN: begin
                if (beat) begin
                    s_d.phase = PH_PAY;
                    s_d.cnt   = '0;
                end
            end
            PH_PAY: begin
                if (beat) begin
                    if (s_q.cnt == s_q.wlen - CNT_W'(1)) begin
                        s_d.phase = (s_q.kind == KIND_WRRD) ? PH_RLEN : PH_CRC_LO;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            end
            PH_RLEN: begin
                if (beat) s_d.phase = PH_CRC_LO;
            end
            PH_CRC_LO: begin
                if (beat) s_d.phase = PH_CRC_HI;
            end
            PH_CRC_HI: begin
                if (beat) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.kind  <= KIND_WR_STOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign err  = s_q.err;

endmodule

// File: rtl/bfg_checker.sv
module bfg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       pl_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       done,
    input logic       err
);

    AST_FIRST_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_ready) && out_valid) |->
            (out_data inside {8'h4B, 8'h5A, 8'h87, 8'h2D, 8'hD2})); // R1

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && req_ready)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && out_valid)); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11

    AST_PAY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> (out_ready && !req_ready)); // R11

endmodule

bind bridge_frame_gen bfg_checker u_bfg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .pl_ready  (pl_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .err       (err)
);

// File: tb/bridge_frame_gen_tb.sv
module bridge_frame_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = '0;
    logic [6:0] req_addr = '0;
    logic [8:0] req_wlen = '0;
    logic [8:0] req_rlen = '0;
    logic [9:0] req_rate_khz = '0;
    logic       pl_valid = 1'b0;
    logic       pl_ready;
    logic [7:0] pl_data = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       done;
    logic       err;

    always #10 clk = ~clk;

    bridge_frame_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wlen(req_wlen), .req_rlen(req_rlen),
        .req_rate_khz(req_rate_khz),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .err(err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [7:0] pay   [0:299];
    logic [7:0] exp_b [0:599];
    logic [7:0] got_b [0:599];
    int exp_n;
    int got_n;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c;
        for (int k = 0; k < 8; k++) begin
            if ((x[0] ^ b[k]) == 1'b1) x = (x >> 1) ^ 16'hA001;
            else                       x = x >> 1;
        end
        return x;
    endfunction

    function automatic logic [7:0] ref_op(input int kind);
        case (kind)
            0: return 8'h4B;
            1: return 8'h5A;
            2: return 8'h87;
            3: return 8'h2D;
            default: return 8'hD2;
        endcase
    endfunction

    task automatic push_exp(input logic [7:0] b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_exp(input int kind, input int addr, input int wl,
                             input int rl, input int rate);
        logic [15:0] c;
        exp_n = 0;
        push_exp(ref_op(kind));
        if (kind == 4) begin
            push_exp(rate == 100 ? 8'd0 : rate == 400 ? 8'd1 : 8'd2);
            return;
        end
        push_exp({addr[6:0], kind == 2});
        if (kind == 2) begin
            push_exp(rl[7:0]);
        end else begin
            push_exp(wl[7:0]);
            for (int j = 0; j < wl; j++) push_exp(pay[j]);
            if (kind == 3) push_exp(rl[7:0]);
        end
        c = 16'h0000;
        for (int j = 0; j < exp_n; j++) c = ref_crc(c, exp_b[j]);
        push_exp(~c[7:0]);
        push_exp(~c[15:8]);
    endtask

    task automatic run_frame(input int kind, input int addr, input int wl,
                             input int rl, input int rate, input bit stall,
                             input bit junk);
        int pi;
        bit hold;
        int last_beat;
        int done_at;
        bit mism;
        int mism_at;
        string lay;
        for (int j = 0; j < wl; j++) pay[j] = 8'($urandom);
        build_exp(kind, addr, wl, rl, rate);
        got_n = 0; pi = 0; hold = 0; last_beat = -1; done_at = -1;

        @(negedge clk);
        req_valid = 1; req_kind = 3'(kind); req_addr = 7'(addr);
        req_wlen = 9'(wl); req_rlen = 9'(rl); req_rate_khz = 10'(rate);
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            req_kind = 3'd2; req_addr = 7'h55; req_rlen = 9'd3;
        end else begin
            req_valid = 0;
        end

        for (int it = 0; it < 3000; it++) begin
            if (stall && it < 3) out_ready = 0;
            else out_ready = ($urandom % 4) != 0;
            if (!hold) pl_valid = (pi < wl) && (($urandom % 3) != 0);
            pl_data = (pi < wl) ? pay[pi] : 8'h00;
            #1;
            if (it == 0) check(req_ready == 0, "R10", "req_ready during frame", req_ready, 0);
            if (stall && it < 3)
                check(out_valid && out_data == exp_b[0], "R11", "held byte under stall",
                      out_data, exp_b[0]);
            if (done) begin
                done_at = it;
                req_valid = 0;
                break;
            end
            if (out_valid && out_ready) begin
                if (got_n < 600) got_b[got_n] = out_data;
                got_n++;
                last_beat = it;
            end
            if (pl_valid && pl_ready) begin
                pi++;
                hold = 0;
            end else begin
                hold = pl_valid;
            end
            @(posedge clk);
            @(negedge clk);
        end
        pl_valid = 0;
        out_ready = 0;

        check(got_n > 0 && got_b[0] == exp_b[0], "R1", "command byte", got_b[0], exp_b[0]);
        if (kind != 4)
            check(got_n > 1 && got_b[1] == exp_b[1], "R2", "address byte", got_b[1], exp_b[1]);
        mism = (got_n != exp_n);
        mism_at = -1;
        for (int j = 0; j < exp_n && j < got_n; j++)
            if (!mism && got_b[j] != exp_b[j]) begin mism = 1; mism_at = j; end
        case (kind)
            2: lay = "R4 read frame";
            3: lay = "R5 write-read frame";
            4: lay = "R8 speed frame";
            default: lay = "R3 write frame";
        endcase
        if (mism_at >= 0)
            check(0, lay, $sformatf("byte %0d", mism_at), got_b[mism_at], exp_b[mism_at]);
        else
            check(!mism, lay, "frame length", got_n, exp_n);
        if (kind != 4 && got_n == exp_n)
            check({got_b[exp_n-1], got_b[exp_n-2]} == {exp_b[exp_n-1], exp_b[exp_n-2]},
                  "R6", "check bytes", {got_b[exp_n-1], got_b[exp_n-2]},
                  {exp_b[exp_n-1], exp_b[exp_n-2]});
        check(done_at >= 0 && done_at == last_beat + 1, "R9", "done timing", done_at, last_beat + 1);
        @(negedge clk);
        #1;
        check(done == 0, "R9", "done one cycle wide", done, 0);
    endtask

    task automatic reject(input int kind, input int wl, input int rl, input int rate,
                          input string req);
        bit seen_out;
        @(negedge clk);
        req_valid = 1; req_kind = 3'(kind); req_addr = 7'h12;
        req_wlen = 9'(wl); req_rlen = 9'(rl); req_rate_khz = 10'(rate);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        check(err == 1, req, "error pulse", err, 1);
        seen_out = out_valid;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            #1;
            seen_out |= out_valid;
        end
        check(!seen_out && req_ready, req, "no frame after refusal", seen_out, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        check(req_ready == 1 && out_valid == 0 && done == 0 && err == 0, "R10",
              "reset state", {req_ready, out_valid, done, err}, 4'b1000);
        rst_n = 1;

        // Directed corner cases.
        run_frame(0, 7'h50, 1, 0, 0, 1, 0);
        run_frame(1, 7'h7F, 3, 0, 0, 0, 1);
        run_frame(2, 7'h01, 0, 255, 0, 0, 0);
        run_frame(3, 7'h2A, 2, 4, 0, 0, 0);
        run_frame(0, 7'h00, 255, 0, 0, 0, 0);
        run_frame(4, 0, 0, 0, 100, 0, 0);
        run_frame(4, 0, 0, 0, 400, 0, 0);
        run_frame(4, 0, 0, 0, 900, 0, 0);

        reject(0, 0, 5, 0, "R7");
        reject(1, 256, 5, 0, "R7");
        reject(2, 4, 0, 0, "R7");
        reject(3, 4, 300, 0, "R7");
        reject(4, 0, 0, 500, "R8");
        reject(7, 4, 4, 400, "R1");

        // Random frames.
        for (int f = 0; f < 40; f++) begin
            int k;
            int r;
            k = $urandom % 5;
            r = $urandom % 3;
            run_frame(k, $urandom % 128, 1 + ($urandom % 20), 1 + ($urandom % 255),
                      r == 0 ? 100 : r == 1 ? 400 : 900, 0, ($urandom % 4) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule